// File: doc/BRIEF.md
# USB Pipe Response and Sequence-Toggle Control

This block is the control register of one pipe in a USB host/function controller. It holds the handshake that the pipe returns, the DATA0/DATA1 sequence bit and the auto buffer clear enable. Software writes and reads it through a plain register port. The transaction engine drives two sideband pulses into it. One marks a successful transaction and advances the sequence bit. The other marks a transfer error and makes the block take the handshake over itself.

In host mode the block reports whether a token may be sent for the pipe. In function mode it tells the engine which handshake to reply with. Toggle changes that software asks for are accepted only while the pipe is quiet: the handshake must be NAK, and the pipe must not be isochronous for a forced DATA1. Writing 1 to both strobes in one write is treated as a conflict and does nothing.

Top module: `usb_pipe_ctrl`

## Requirements
- R1: After reset, `rdata_o` reads 0 (NAK, DATA0, auto clear off), `token_ok_o` is 0, `resp_hs_o` is 00 and `buf_clr_req_o` is 0.
- R2: Read bits 8, 7 and 5:2 are always 0, whatever was written to them.
- R3: A write with bit 8 = 1 and bit 7 = 0 sets the sequence bit to DATA0. A write with bit 7 = 1 and bit 8 = 0 sets it to DATA1. Either takes effect only if the stored PID is NAK (00) before the write. The sequence bit shows in read bit 6 from the next cycle on (0 = DATA0).
- R4: The sequence bit does not change when a strobe is written while the stored PID is not NAK, when bits 8 and 7 are both written as 1, or when they are written as 0.
- R5: While `xfer_type_i` is 11 (isochronous), a DATA1 strobe has no effect.
- R6: When no strobe takes effect, a `txn_ok_i` pulse inverts the sequence bit. On an isochronous pipe it sets the bit to DATA0 instead. An accepted strobe wins over `txn_ok_i` in the same cycle.
- R7: PID bits 1:0 are stored as written and read back on bits 1:0. `resp_hs_o` is 00 for PID 00 (NAK), 01 for PID 01 (BUF) and 10 for both 10 and 11 (STALL).
- R8: `token_ok_o` is 1 exactly when `host_mode_i` is 1 and the stored PID is 01.
- R9: A `xfer_err_i` pulse makes the stored PID 10 in the next cycle. It overrides a software PID write in the same cycle.
- R10: Read bit 9 holds the last written auto clear enable, and `buf_clr_req_o` is 1 while that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 10 | Register write data |
| rdata_o | output | 10 | Register read data |
| xfer_type_i | input | 2 | Pipe transfer type, 11 = isochronous |
| host_mode_i | input | 1 | 1 = host role, 0 = function role |
| txn_ok_i | input | 1 | Successful transaction pulse |
| xfer_err_i | input | 1 | Transfer error pulse |
| token_ok_o | output | 1 | Host mode: a token may be issued |
| resp_hs_o | output | 2 | Function mode handshake: 00 NAK, 01 BUF, 10 STALL |
| buf_clr_req_o | output | 1 | Request to initialize the pipe buffers |

## Verification
Every register in the block can be read through `rdata_o` one cycle after the edge that loads it. A corrupted PID, sequence bit or clear enable therefore shows up on the next compare. A wrong PID also shows on `token_ok_o` and `resp_hs_o` in that same cycle. A wrongly gated strobe, or a wrong choice between strobe and `txn_ok_i`, leaves bit 6 at the wrong value one cycle after the write. The reference model catches that on the following clock.

// File: rtl/usb_pipe_pkg.sv
package usb_pipe_pkg;
  localparam int unsigned REG_W   = 10;
  localparam int unsigned PID_W   = 2;
  localparam int unsigned TYPE_W  = 2;
  localparam int unsigned BIT_ACLR = 9;
  localparam int unsigned BIT_CLR  = 8;
  localparam int unsigned BIT_SET  = 7;
  localparam int unsigned BIT_SEQ  = 6;
  localparam logic [TYPE_W-1:0] TYPE_ISO = 2'b11;

  typedef enum logic [PID_W-1:0] {
    HS_NAK   = 2'b00,
    HS_BUF   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;
endpackage

// File: rtl/pipe_pid_ctl.sv
module pipe_pid_ctl
  import usb_pipe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic             xfer_err_i,
  input  logic             host_mode_i,
  output logic [PID_W-1:0] pid_o,
  output logic             pid_nak_o,
  output logic             token_ok_o,
  output hs_e              resp_hs_o
);
  logic [PID_W-1:0] pid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pid_q <= HS_NAK;
    else if (xfer_err_i) pid_q <= HS_STALL;   // hardware wins over software
    else if (wr_en_i)    pid_q <= wr_pid_i;
  end

  always_comb begin
    unique case (pid_q)
      2'b00:   resp_hs_o = HS_NAK;
      2'b01:   resp_hs_o = HS_BUF;
      default: resp_hs_o = HS_STALL;
    endcase
  end

  assign pid_o      = pid_q;
  assign pid_nak_o  = (pid_q == HS_NAK);
  assign token_ok_o = host_mode_i && (resp_hs_o == HS_BUF);

  AST_ERR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_i |=> pid_o == HS_STALL); // R9
  AST_WR_PID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !xfer_err_i) |=> pid_o == $past(wr_pid_i)); // R7
endmodule

// File: rtl/pipe_seq_ctl.sv
module pipe_seq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic pid_nak_i,
  input  logic iso_i,
  input  logic txn_ok_i,
  output logic seq_o
);
  logic seq_q, do_clr, do_set;

  // strobes act only while NAK and never together
  assign do_clr = wr_en_i && clr_i && !set_i && pid_nak_i;
  assign do_set = wr_en_i && set_i && !clr_i && pid_nak_i && !iso_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seq_q <= 1'b0;
    else if (do_clr)   seq_q <= 1'b0;
    else if (do_set)   seq_q <= 1'b1;
    else if (txn_ok_i) seq_q <= iso_i ? 1'b0 : ~seq_q;
  end

  assign seq_o = seq_q;

  AST_CLR_DATA0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clr_i && !set_i && pid_nak_i) |=> !seq_o); // R3
  AST_GATE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (clr_i || set_i) && !pid_nak_i && !txn_ok_i) |=> $stable(seq_o)); // R4
  AST_BOTH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clr_i && set_i && !txn_ok_i) |=> $stable(seq_o)); // R4
  AST_ISO_DATA0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_i && txn_ok_i) |=> !seq_o); // R6
  AST_ISO_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_i && wr_en_i && set_i && !clr_i && !txn_ok_i) |=> $stable(seq_o)); // R5
endmodule

// File: rtl/usb_pipe_ctrl.sv
module usb_pipe_ctrl
  import usb_pipe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [TYPE_W-1:0] xfer_type_i,
  input  logic              host_mode_i,
  input  logic              txn_ok_i,
  input  logic              xfer_err_i,
  output logic              token_ok_o,
  output logic [PID_W-1:0]  resp_hs_o,
  output logic              buf_clr_req_o
);
  logic [PID_W-1:0] pid;
  logic             pid_nak, seq, aclr_q;
  hs_e              hs;
  logic             unused_rsvd;

  assign unused_rsvd = ^wdata_i[BIT_SEQ:PID_W];

  pipe_pid_ctl u_pid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_pid_i   (wdata_i[PID_W-1:0]),
    .xfer_err_i (xfer_err_i),
    .host_mode_i(host_mode_i),
    .pid_o      (pid),
    .pid_nak_o  (pid_nak),
    .token_ok_o (token_ok_o),
    .resp_hs_o  (hs)
  );

  pipe_seq_ctl u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .clr_i    (wdata_i[BIT_CLR]),
    .set_i    (wdata_i[BIT_SET]),
    .pid_nak_i(pid_nak),
    .iso_i    (xfer_type_i == TYPE_ISO),
    .txn_ok_i (txn_ok_i),
    .seq_o    (seq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      aclr_q <= 1'b0;
    else if (wr_en_i) aclr_q <= wdata_i[BIT_ACLR];
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[BIT_ACLR]      = aclr_q;
    rdata_o[BIT_SEQ]       = seq;
    rdata_o[PID_W-1:0]     = pid;
  end

  assign resp_hs_o     = hs;
  assign buf_clr_req_o = aclr_q;

  AST_TOKEN_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_ok_o |-> (rdata_o[PID_W-1:0] == 2'b01)); // R8
  AST_STALL_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[1] |-> (resp_hs_o == HS_STALL)); // R7
  AST_ACLR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (buf_clr_req_o == $past(wdata_i[BIT_ACLR]))); // R10
endmodule

// File: tb/sim_usb_pipe_ctrl.sv
module sim_usb_pipe_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 0, host = 0, ok = 0, err = 0;
  logic [9:0] wd = '0;
  logic [1:0] typ = '0;
  logic [9:0] rdata;
  logic       token, req;
  logic [1:0] hs;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic       done = 0;

  logic [1:0] m_pid;
  logic       m_seq, m_aclr;

  always #4 clk = ~clk;  // 125 MHz

  usb_pipe_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wdata_i(wd), .rdata_o(rdata),
    .xfer_type_i(typ), .host_mode_i(host), .txn_ok_i(ok), .xfer_err_i(err),
    .token_ok_o(token), .resp_hs_o(hs), .buf_clr_req_o(req)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pid <= 0; m_seq <= 0; m_aclr <= 0;
    end else begin
      bit is_iso, nak, c, s;
      is_iso = (typ == 2'd3);
      nak    = (m_pid == 0);
      c = wr && wd[8] && !wd[7] && nak;
      s = wr && wd[7] && !wd[8] && nak && !is_iso;
      if (c)       m_seq <= 0;
      else if (s)  m_seq <= 1;
      else if (ok) m_seq <= is_iso ? 1'b0 : !m_seq;
      if (err)     m_pid <= 2;
      else if (wr) m_pid <= wd[1:0];
      if (wr)      m_aclr <= wd[9];
    end
  end

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int exp_hs;
      exp_hs = (m_pid == 0) ? 0 : (m_pid == 1) ? 1 : 2;
      chk(rdata[1:0] == m_pid, "R7 pid", rdata[1:0], m_pid);
      chk(rdata[6] == m_seq, "R3 seq", rdata[6], m_seq);
      chk(rdata[9] == m_aclr, "R10 aclr", rdata[9], m_aclr);
      chk(rdata[8:7] == 0 && rdata[5:2] == 0, "R2 rsvd", rdata, 0);
      chk(int'(hs) == exp_hs, "R7 hs", hs, exp_hs);
      chk(token == (host && m_pid == 1), "R8 token", token, host && m_pid == 1);
      chk(req == m_aclr, "R10 req", req, m_aclr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(input bit w, input logic [9:0] d, input logic [1:0] t,
                      input bit h, input bit o, input bit e);
    @(negedge clk);
    wr = w; wd = d; typ = t; host = h; ok = o; err = e;
  endtask

  task automatic idle();
    step(0, '0, typ, host, 0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(rdata == 0 && token == 0 && hs == 0 && req == 0, "R1 reset", rdata, 0);
    rst_n = 1;
    // R2 reserved writes ignored
    step(1, 10'b0000111100, 0, 0, 0, 0); idle();
    @(posedge clk); #2;
    chk(rdata[5:2] == 0, "R2 wr rsvd", rdata[5:2], 0);
    // R3 set DATA1 while NAK
    step(1, 10'b0010000000, 0, 0, 0, 0); idle();
    @(posedge clk); #2;
    chk(rdata[6] == 1, "R3 set", rdata[6], 1);
    // R4 both strobes
    step(1, 10'b0110000000, 0, 0, 0, 0); idle();
    @(posedge clk); #2;
    chk(rdata[6] == 1, "R4 both", rdata[6], 1);
    // R4 PID BUF then clear strobe ignored
    step(1, 10'b0000000001, 0, 1, 0, 0);
    step(1, 10'b0100000001, 0, 1, 0, 0); idle();
    @(posedge clk); #2;
    chk(rdata[6] == 1, "R4 busy", rdata[6], 1);
    chk(token == 1, "R8 host BUF", token, 1);
    // R6 toggle on success
    step(0, '0, 0, 1, 1, 0); idle();
    @(posedge clk); #2;
    chk(rdata[6] == 0, "R6 toggle", rdata[6], 0);
    // R9 error beats write
    step(1, 10'b0000000001, 0, 1, 0, 1); idle();
    @(posedge clk); #2;
    chk(rdata[1:0] == 2 && token == 0, "R9 err", rdata[1:0], 2);
    // R5 iso set ignored
    step(1, 10'b0000000000, 3, 0, 0, 0);
    step(1, 10'b0010000000, 3, 0, 0, 0); idle();
    @(posedge clk); #2;
    chk(rdata[6] == 0, "R5 iso set", rdata[6], 0);
    // R6 iso success stays DATA0
    step(0, '0, 3, 0, 1, 0); idle();
    @(posedge clk); #2;
    chk(rdata[6] == 0, "R6 iso", rdata[6], 0);
    // R7 PID 11 behaves as STALL, R10 aclr
    step(1, 10'b1000000011, 0, 0, 0, 0); idle();
    @(posedge clk); #2;
    chk(hs == 2 && req == 1, "R7 pid11", hs, 2);
    // randomized traffic, model-compared
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] d;
      d = 10'($urandom);
      if ($urandom_range(0, 2) == 0) d[1:0] = 0;
      step($urandom_range(0, 2) == 0, d, 2'($urandom), 1'($urandom),
           $urandom_range(0, 3) == 0, $urandom_range(0, 15) == 0);
    end
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule